// File: doc/BRIEF.md
# Event-to-Virtual-Interrupt Aggregator

This block collects event messages that arrive one per cycle on a strobe interface. Each message carries a global event number and an up/down flag. A lookup table translates the event number into a destination: one bit position inside one virtual interrupt group. An up event sets that pending bit, and a down event clears it. A down event serves sources that hold a level and withdraw it themselves.

Each group has 64 pending bits and a 64-bit enable mask. Software sets enable bits with one write-one address and clears them with another. Software acknowledges pulse-type events by writing ones to the raw pending register. Software reads a masked view to find which enabled events are pending. Each group drives one registered, active-high level interrupt, which is high while any enabled bit is pending.

One memory-mapped port with 64-bit data reaches all group windows and the lookup table. An event whose table entry is not valid, or that names a group that does not exist, is dropped and raises a sticky error flag.

Top module: `evt_vint_agg`

## Requirements
- R1: After reset, every enable bit, every pending bit, every table valid bit, every `irq` bit and `drop_err` are zero.
- R2: Group n occupies the 4 KiB window at byte address n*0x1000. In that window, offsets 0x0 and 0x8 both read back the enable mask, 0x18 reads the raw pending bits, and 0x20 reads the masked view. Any other offset, and any window that belongs to neither a group nor the table, reads zero. `reg_rdata` carries the data in the cycle after `reg_rd` is sampled and is zero in every other cycle.
- R3: A write to offset 0x0 sets the enable bits where the write data has ones. The other enable bits keep their values.
- R4: A write to offset 0x8 clears the enable bits where the write data has ones. The other enable bits keep their values.
- R5: A write to offset 0x18 clears the pending bits where the write data has ones. A write to offset 0x20 changes nothing.
- R6: The masked view at 0x20 equals the raw pending bits ANDed with the enable mask.
- R7: The lookup table occupies the topmost window, with the entry for event e at offset e*8. In a table word, bit 31 is the valid bit, bits 15:8 hold the group number and bits 5:0 hold the bit index. An entry written with bit 31 clear reads back as zero.
- R8: An up event that hits a valid entry sets the mapped pending bit. The bit is visible to a read issued two cycles after the strobe.
- R9: A down event that hits a valid entry clears the mapped pending bit and leaves every other bit unchanged.
- R10: An event whose entry is invalid, or whose group number is not below NUM_GROUPS, changes no pending bit and sets `drop_err`. `drop_err` then stays high until reset.
- R11: If an event sets a pending bit in the same cycle that a software write clears that bit, the bit ends up set.
- R12: `irq[g]` is high exactly when group g has a pending bit that is also enabled. It follows a change of pending or enable bits one cycle later, so it rises three cycles after the strobe of the event that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event strobe |
| evt_num | input | EVT_W | Global event number |
| evt_down | input | 1 | 1 = down event (clear bit), 0 = up event (set bit) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after the read strobe |
| irq | output | NUM_GROUPS | Per-group level interrupt |
| drop_err | output | 1 | Sticky flag for dropped events |

## Verification
The bench programs every table entry and reads each one back. It then fires every mapped event and compares each group's raw and masked registers with an arithmetic model. A design with the wrong bit routing or the wrong window decode shows up as a mismatch at a specific bit.

Several corner cases get their own tests. Writes of zero bits to the set and clear addresses catch a design that overwrites the enable mask instead of updating single bits. A write to the masked view catches a design that treats it as writable. A set event that coincides with a software clear of the same bit catches a design that gives the clear priority.

The interrupt is sampled on each cycle around an event and around an acknowledge. This catches a design whose interrupt arrives one cycle early or late. Dropped events are tested with both an out-of-range group and an invalid entry, which catches a design that writes a pending bit anyway or lets the error flag fall.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;
  localparam int unsigned VINT_BITS = 64;
  localparam int unsigned BIT_IDX_W = 6;
  localparam int unsigned GRP_ID_W  = 8;

  typedef struct packed {
    logic [GRP_ID_W-1:0]  grp;
    logic [BIT_IDX_W-1:0] bidx;
  } map_ent_t;

  typedef enum logic [2:0] {
    OFF_EN_SET,
    OFF_EN_CLR,
    OFF_RAW,
    OFF_MASKED,
    OFF_NONE
  } win_off_e;

  function automatic win_off_e decode_off(logic [11:0] off);
    case (off)
      12'h000: decode_off = OFF_EN_SET;
      12'h008: decode_off = OFF_EN_CLR;
      12'h018: decode_off = OFF_RAW;
      12'h020: decode_off = OFF_MASKED;
      default: decode_off = OFF_NONE;
    endcase
  endfunction
endpackage

// File: rtl/evt_map_table.sv
module evt_map_table
  import evt_agg_pkg::*;
#(
  parameter int EVT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [EVT_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  map_ent_t         wr_ent,
  input  logic [EVT_W-1:0] lk_idx,
  output logic             lk_valid,
  output map_ent_t         lk_ent,
  input  logic [EVT_W-1:0] rb_idx,
  output logic             rb_valid,
  output map_ent_t         rb_ent
);
  localparam int DEPTH = 1 << EVT_W;

  // Entry payload lives in a RAM with synchronous reads (block-RAM friendly).
  map_ent_t         mem [DEPTH];
  // Valid bits live in flops so that reset can clear them.
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_ent;
    lk_ent <= mem[lk_idx];
    rb_ent <= mem[rb_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      lk_valid <= 1'b0;
      rb_valid <= 1'b0;
    end else begin
      if (wr_en) vld[wr_idx] <= wr_valid;
      lk_valid <= vld[lk_idx];
      rb_valid <= vld[rb_idx];
    end
  end
endmodule

// File: rtl/vint_group.sv
module vint_group
  import evt_agg_pkg::*;
#(
  parameter int BITS = VINT_BITS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel,
  input  logic            wr,
  input  win_off_e        kind,
  input  logic [BITS-1:0] wdata,
  input  logic [BITS-1:0] ev_set,
  input  logic [BITS-1:0] ev_clr,
  output logic [BITS-1:0] enable,
  output logic [BITS-1:0] status,
  output logic            irq
);
  logic            wr_here;
  logic [BITS-1:0] en_set, en_clr, sw_ack;

  assign wr_here = sel && wr;
  assign en_set  = (wr_here && kind == OFF_EN_SET) ? wdata : '0;
  assign en_clr  = (wr_here && kind == OFF_EN_CLR) ? wdata : '0;
  assign sw_ack  = (wr_here && kind == OFF_RAW)    ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      enable <= (enable | en_set) & ~en_clr;
      // An event set is applied last, so it wins over a software acknowledge.
      status <= (status & ~(sw_ack | ev_clr)) | ev_set;
      irq    <= |(status & enable);
    end
  end
endmodule

// File: rtl/evt_vint_agg.sv
module evt_vint_agg
  import evt_agg_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int EVT_W      = 6,
  parameter int ADDR_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  evt_valid,
  input  logic [EVT_W-1:0]      evt_num,
  input  logic                  evt_down,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [63:0]           reg_wdata,
  output logic [63:0]           reg_rdata,
  output logic [NUM_GROUPS-1:0] irq,
  output logic                  drop_err
);
  localparam int              WIN_W   = ADDR_W - 12;
  localparam logic [WIN_W-1:0] MAP_WIN = '1;
  localparam int              DEPTH   = 1 << EVT_W;

  // ---------------- address decode ----------------
  logic [WIN_W-1:0] win;
  logic [11:0]      off;
  win_off_e         kind;
  logic             map_sel;
  logic [EVT_W-1:0] map_idx;

  assign win     = reg_addr[ADDR_W-1:12];
  assign off     = reg_addr[11:0];
  assign kind    = decode_off(off);
  assign map_sel = (win == MAP_WIN) && (off[2:0] == 3'b000) && (32'(off[11:3]) < DEPTH);
  assign map_idx = off[EVT_W+2:3];

  // ---------------- mapping table ----------------
  logic     lk_valid, rb_valid;
  map_ent_t lk_ent, rb_ent, wr_ent;

  assign wr_ent.grp  = reg_wdata[15:8];
  assign wr_ent.bidx = reg_wdata[5:0];

  evt_map_table #(.EVT_W(EVT_W)) u_map (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr && map_sel),
    .wr_idx  (map_idx),
    .wr_valid(reg_wdata[31]),
    .wr_ent  (wr_ent),
    .lk_idx  (evt_num),
    .lk_valid(lk_valid),
    .lk_ent  (lk_ent),
    .rb_idx  (map_idx),
    .rb_valid(rb_valid),
    .rb_ent  (rb_ent)
  );

  // ---------------- event pipeline ----------------
  logic s1_valid, s1_down;
  logic hit, miss;
  logic [VINT_BITS-1:0] bit_oh;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_down  <= 1'b0;
    end else begin
      s1_valid <= evt_valid;
      s1_down  <= evt_down;
    end
  end

  assign hit    = s1_valid && lk_valid && (32'(lk_ent.grp) < NUM_GROUPS);
  assign miss   = s1_valid && !hit;
  assign bit_oh = VINT_BITS'(1) << lk_ent.bidx;

  always_ff @(posedge clk) begin
    if (rst)       drop_err <= 1'b0;
    else if (miss) drop_err <= 1'b1;
  end

  // ---------------- vint groups ----------------
  logic [VINT_BITS-1:0] en_arr [NUM_GROUPS];
  logic [VINT_BITS-1:0] st_arr [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic                 grp_hit;
    logic [VINT_BITS-1:0] ev_set, ev_clr;

    assign grp_hit = hit && (32'(lk_ent.grp) == g);
    assign ev_set  = (grp_hit && !s1_down) ? bit_oh : '0;
    assign ev_clr  = (grp_hit &&  s1_down) ? bit_oh : '0;

    vint_group #(.BITS(VINT_BITS)) u_grp (
      .clk   (clk),
      .rst   (rst),
      .sel   (32'(win) == g),
      .wr    (reg_wr),
      .kind  (kind),
      .wdata (reg_wdata),
      .ev_set(ev_set),
      .ev_clr(ev_clr),
      .enable(en_arr[g]),
      .status(st_arr[g]),
      .irq   (irq[g])
    );
  end

  // ---------------- read path ----------------
  logic [63:0] grp_rd;
  logic [63:0] val_q;
  logic        rd_q, map_q;

  always_comb begin
    grp_rd = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (32'(win) == g) begin
        case (kind)
          OFF_EN_SET, OFF_EN_CLR: grp_rd = en_arr[g];
          OFF_RAW:                grp_rd = st_arr[g];
          OFF_MASKED:             grp_rd = st_arr[g] & en_arr[g];
          default:                grp_rd = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= 1'b0;
      map_q <= 1'b0;
      val_q <= '0;
    end else begin
      rd_q  <= reg_rd;
      map_q <= map_sel;
      val_q <= grp_rd;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (rd_q) begin
      if (map_q) begin
        if (rb_valid) reg_rdata = {32'b0, 1'b1, 15'b0, rb_ent.grp, 2'b0, rb_ent.bidx};
      end else begin
        reg_rdata = val_q;
      end
    end
  end
endmodule

// File: rtl/evt_vint_agg_chk.sv
module evt_vint_agg_chk #(
  parameter int NUM_GROUPS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  evt_valid,
  input logic                  reg_wr,
  input logic                  reg_rd,
  input logic [63:0]           reg_rdata,
  input logic [NUM_GROUPS-1:0] irq,
  input logic                  drop_err
);
  // Counts edges since reset so that $past never reaches back into reset.
  logic [1:0] age;
  logic       armed;

  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign armed = (age == 2'd3);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    drop_err |=> drop_err); // R10

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(drop_err)) |-> $past(evt_valid, 2)); // R10

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == 64'd0)); // R2

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_irq
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
      (armed && $rose(irq[g])) |-> ($past(evt_valid, 3) || $past(reg_wr, 2))); // R12

    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
      (armed && $fell(irq[g])) |-> ($past(evt_valid, 3) || $past(reg_wr, 2))); // R12
  end
endmodule

bind evt_vint_agg evt_vint_agg_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (.*);

// File: tb/evt_vint_agg_test.sv
module evt_vint_agg_test;
  localparam int CLK_PERIOD = 10;
  localparam int NG         = 2;
  localparam int EW         = 4;
  localparam int AW         = 16;
  localparam logic [15:0] MAP_BASE = 16'hF000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          evt_valid = 1'b0;
  logic [EW-1:0] evt_num = '0;
  logic          evt_down = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata;
  logic [NG-1:0] irq;
  logic          drop_err;

  int checks = 0;
  int errors = 0;

  // bench-side model
  logic [63:0] m_stat [NG];
  logic [63:0] m_en   [NG];
  logic        m_vld  [16];
  int          m_grp  [16];
  int          m_bit  [16];
  logic        m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_vint_agg #(.NUM_GROUPS(NG), .EVT_W(EW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_num(evt_num),
    .evt_down(evt_down), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .drop_err(drop_err)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_wr(logic [15:0] a, logic [63:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [15:0] a, logic [63:0] exp, string tag);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic send(int e, logic dn);
    evt_valid = 1'b1; evt_num = EW'(e); evt_down = dn;
    @(negedge clk);
    evt_valid = 1'b0; evt_down = 1'b0;
    @(negedge clk);
    if (!m_vld[e] || m_grp[e] >= NG) m_err = 1'b1;
    else if (dn) m_stat[m_grp[e]] &= ~(64'd1 << m_bit[e]);
    else         m_stat[m_grp[e]] |=  (64'd1 << m_bit[e]);
  endtask

  task automatic irq_chk(string tag);
    logic [NG-1:0] exp;
    for (int g = 0; g < NG; g++) exp[g] = |(m_stat[g] & m_en[g]);
    chk(tag, 64'(irq), 64'(exp));
  endtask

  task automatic grp_chk(string tag);
    for (int g = 0; g < NG; g++) begin
      rd_chk(16'(g * 16'h1000 + 16'h18), m_stat[g], tag);
      rd_chk(16'(g * 16'h1000 + 16'h20), m_stat[g] & m_en[g], "R6 masked view");
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) begin m_stat[g] = '0; m_en[g] = '0; end
    for (int e = 0; e < 16; e++) begin
      m_vld[e] = 1'b0; m_grp[e] = e & 1; m_bit[e] = ((e >> 1) * 7) % 64;
    end
    m_err = 1'b0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", 64'(irq), 64'd0);
    chk("R1 drop_err after reset", 64'(drop_err), 64'd0);
    for (int g = 0; g < NG; g++) begin
      rd_chk(16'(g * 16'h1000), 64'd0, "R1 enable reset");
      rd_chk(16'(g * 16'h1000 + 16'h18), 64'd0, "R1 status reset");
    end
    for (int e = 0; e < 16; e++) rd_chk(MAP_BASE + 16'(e * 8), 64'd0, "R1 table valid reset");

    // R7 program the table for events 0..14 and read each entry back
    for (int e = 0; e < 15; e++) begin
      do_wr(MAP_BASE + 16'(e * 8), 64'h8000_0000 | 64'(m_grp[e] << 8) | 64'(m_bit[e]));
      m_vld[e] = 1'b1;
    end
    for (int e = 0; e < 15; e++)
      rd_chk(MAP_BASE + 16'(e * 8), 64'h8000_0000 | 64'(m_grp[e] << 8) | 64'(m_bit[e]), "R7 table readback");
    do_wr(MAP_BASE + 16'(15 * 8), 64'h0000_0000_0000_0F2A);
    rd_chk(MAP_BASE + 16'(15 * 8), 64'd0, "R7 invalid entry reads zero");

    // R2 unmapped offsets and windows
    rd_chk(16'h0010, 64'd0, "R2 unmapped offset");
    rd_chk(16'h0028, 64'd0, "R2 unmapped offset");
    rd_chk(16'h0004, 64'd0, "R2 misaligned offset");
    rd_chk(16'h2000, 64'd0, "R2 window beyond groups");

    // R8 every mapped up event
    for (int e = 0; e < 15; e++) send(e, 1'b0);
    grp_chk("R8 status after up events");
    @(negedge clk);
    irq_chk("R12 irq with enables clear");

    // R3 enable set, zero bits leave others
    do_wr(16'h0000, 64'hF0F0_0000_1234_0081); m_en[0] |= 64'hF0F0_0000_1234_0081;
    do_wr(16'h0000, 64'h0000_0000_0000_4000); m_en[0] |= 64'h0000_0000_0000_4000;
    rd_chk(16'h0000, m_en[0], "R3 enable set");
    rd_chk(16'h0008, m_en[0], "R2 enable at clear offset");
    do_wr(16'h1000, '1); m_en[1] = '1;
    rd_chk(16'h1000, m_en[1], "R3 enable set all");
    grp_chk("R6 after enable");
    irq_chk("R12 irq after enable");

    // R4 enable clear
    do_wr(16'h1008, 64'hFFFF_FFFF_0000_0000); m_en[1] &= ~64'hFFFF_FFFF_0000_0000;
    do_wr(16'h0008, 64'h0000_0000_0000_0001); m_en[0] &= ~64'h1;
    rd_chk(16'h1000, m_en[1], "R4 enable clear");
    rd_chk(16'h0000, m_en[0], "R4 enable clear single");

    // R5 acknowledge and masked-view write
    do_wr(16'h0018, 64'h0000_0000_0020_4001); m_stat[0] &= ~64'h0000_0000_0020_4001;
    do_wr(16'h1020, '1);
    do_wr(16'h0020, '1);
    grp_chk("R5 status after ack and masked write");

    // R9 down events
    send(2, 1'b1);
    send(3, 1'b1);
    send(3, 1'b1);
    grp_chk("R9 status after down");
    send(2, 1'b0);
    grp_chk("R8 status after re-up");

    // R11 set versus acknowledge in the same cycle
    do_wr(16'h0018, 64'd1 << m_bit[4]); m_stat[0] &= ~(64'd1 << m_bit[4]);
    send(0, 1'b0);
    evt_valid = 1'b1; evt_num = 4'd4; evt_down = 1'b0;
    @(negedge clk);
    evt_valid = 1'b0;
    reg_addr = 16'h0018; reg_wdata = (64'd1 << m_bit[4]) | 64'd1; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    m_stat[0] &= ~64'd1; m_stat[0] |= 64'd1 << m_bit[4];
    rd_chk(16'h0018, m_stat[0], "R11 set wins over ack");

    // R12 irq timing around an event and an acknowledge
    do_wr(16'h0008, '1); m_en[0] = '0;
    do_wr(16'h0018, '1); m_stat[0] = '0;
    do_wr(16'h0000, 64'd1 << m_bit[6]); m_en[0] = 64'd1 << m_bit[6];
    @(negedge clk);
    chk("R12 irq idle", 64'(irq[0]), 64'd0);
    evt_valid = 1'b1; evt_num = 4'd6; evt_down = 1'b0;
    @(negedge clk);
    evt_valid = 1'b0;
    chk("R12 irq one cycle after strobe", 64'(irq[0]), 64'd0);
    @(negedge clk);
    chk("R12 irq two cycles after strobe", 64'(irq[0]), 64'd0);
    @(negedge clk);
    chk("R12 irq three cycles after strobe", 64'(irq[0]), 64'd1);
    m_stat[0] = 64'd1 << m_bit[6];
    reg_addr = 16'h0018; reg_wdata = 64'd1 << m_bit[6]; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R12 irq held in ack cycle", 64'(irq[0]), 64'd1);
    @(negedge clk);
    chk("R12 irq falls after ack", 64'(irq[0]), 64'd0);
    m_stat[0] = '0;

    // R10 group out of range, then invalid entry
    chk("R10 no error yet", 64'(drop_err), 64'd0);
    do_wr(MAP_BASE + 16'(13 * 8), 64'h8000_0000 | 64'(5 << 8) | 64'd3);
    m_grp[13] = 5; m_bit[13] = 3;
    send(13, 1'b0);
    @(negedge clk);
    chk("R10 error on bad group", 64'(drop_err), 64'(m_err));
    grp_chk("R10 status unchanged bad group");
    send(15, 1'b0);
    @(negedge clk);
    grp_chk("R10 status unchanged invalid entry");
    repeat (4) @(negedge clk);
    chk("R10 error sticky", 64'(drop_err), 64'd1);

    // R9 near-exhaustive down sweep
    for (int e = 0; e < 13; e++) send(e, 1'b1);
    grp_chk("R9 status after down sweep");
    @(negedge clk);
    irq_chk("R12 irq after down sweep");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule